// File: doc/BRIEF.md
# SDRAM Command Sequencer with Refresh Scheduling

This block sits between a simple host request port and a single-rank SDRAM device. After reset it brings the memory up through a fixed start-up sequence, then turns each accepted word request into a row open, one column access and a row close. Every command leaves the required number of clock cycles after the one before it. A free-running interval timer marks when an auto-refresh is owed. The sequencer issues it the next time no row is open, and it takes precedence over a host request that is waiting.

The host raises `req_valid` with a direction flag and a bank, row and column address. The request is taken on a clock edge where `req_ready` is high, and `req_done` pulses once the row has been closed again. All gap lengths are parameters counted in clock cycles. The defaults assume an 8 ns clock: 100 µs start-up wait, 15.6 µs refresh interval, row-to-column 3, precharge 3, row cycle 10, minimum row-active 6, mode-load 2, write recovery 2.

Top module: `sdram_cmd_seq`

## Requirements
- R1: While reset is held, the command pins carry the inhibit pattern (chip select, row strobe, column strobe and write enable all high), the clock enable is low, and `req_ready` and `req_done` are low.
- R2: After reset the clock enable goes high and stays high. Only inhibit is driven for at least T_INIT cycles. The first command is a PRECHARGE with address bit 10 high, meaning all banks.
- R3: Start-up order is PRECHARGE all, AUTO REFRESH, AUTO REFRESH, then LOAD MODE on bank 0 with address word 0x030: burst length 1 in bits 2:0 = 000, sequential in bit 3 = 0, CAS latency 3 in bits 6:4 = 011, all other bits 0. Only after that does `req_ready` assert.
- R4: Commands are encoded as {cs_n, ras_n, cas_n, we_n}: inhibit 1111, NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO REFRESH 0001, LOAD MODE 0000. Idle cycles after start-up carry NOP.
- R5: An ACTIVE carrying the request's bank and row appears in the cycle right after the accepting edge. `req_ready` stays low while a row is open.
- R6: READ (write flag 0) or WRITE (write flag 1) to the same bank appears exactly T_RCD cycles after ACTIVE. The column sits zero-extended in the low address bits, so bit 10 (auto-precharge) is low.
- R7: A single-bank PRECHARGE (bit 10 low, same bank) closes the row at the later of T_RAS cycles after ACTIVE and T_WR cycles after a WRITE (T_RD2PRE after a READ).
- R8: `req_done` is a one-cycle pulse exactly T_RP cycles after that PRECHARGE. Every accepted request yields one pulse.
- R9: Any ACTIVE or AUTO REFRESH is at least T_RC cycles after the previous ACTIVE or AUTO REFRESH, at least T_RP after a PRECHARGE, and at least T_MRD after LOAD MODE.
- R10: After start-up an AUTO REFRESH is owed every T_REFI cycles. It is issued only while no row is open, ahead of any waiting request, so consecutive refreshes lie within T_REFI ± 25 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request taken on this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Bank of the request |
| req_row | input | ROW_W | Row of the request |
| req_col | input | COL_W | Column of the request |
| req_done | output | 1 | One-cycle pulse when the access has closed its row |
| sd_cke | output | 1 | Clock enable to the memory |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | ROW_W | Multiplexed row/column/op-code address |

## Verification
Outputs are registered, so an ACTIVE is due one cycle after the accepting edge and the column command exactly T_RCD cycles later. The PRECHARGE is due at the larger of the row-active and recovery gaps, and `req_done` follows it by exactly T_RP cycles. The bench computes each of these due cycles from its own cycle counter when it drives a request or sees the preceding command. It samples on the falling edge and compares against that exact cycle. Refresh timing depends on where a request happens to fall, so refreshes are checked against a window and against the open-row state rather than against an exact cycle.

// File: rtl/sdram_seq_pkg.sv
// Shared encodings for the SDRAM command sequencer.
// Assumes command pins ordered {cs_n, ras_n, cas_n, we_n}.
package sdram_seq_pkg;

    typedef enum logic [3:0] {
        CMD_INHIBIT = 4'b1111,
        CMD_NOP     = 4'b0111,
        CMD_ACT     = 4'b0011,
        CMD_RD      = 4'b0101,
        CMD_WR      = 4'b0100,
        CMD_PRE     = 4'b0010,
        CMD_REF     = 4'b0001,
        CMD_LMR     = 4'b0000
    } sd_cmd_e;

    typedef enum logic [3:0] {
        ST_RST, ST_PWR, ST_IREF1, ST_IREF2, ST_IMRS, ST_IMRW,
        ST_IDLE, ST_RCD, ST_COL, ST_RP
    } seq_state_e;

    localparam int AP_BIT = 10;        // auto-precharge / all-banks address bit
    localparam int MODE_WORD = 'h030;  // BL1, sequential, CAS latency 3

endpackage

// File: rtl/sdram_gap_timer.sv
// Down-counter that enforces a minimum gap between two commands.
// Loaded with (gap - 1) in the cycle a command is registered;
// expired is high once the following command may be registered.
module sdram_gap_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] value,
    output logic             expired
);

    logic [CNT_W-1:0] cnt;

    // count down to zero, reload on request
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= value;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/sdram_refresh_timer.sv
// Periodic refresh request generator.
// Runs only while enable is high; raises pending once every T_REFI cycles
// and holds it until the sequencer acknowledges the issued refresh.
module sdram_refresh_timer #(
    parameter int T_REFI = 1950
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic ack,
    output logic pending
);

    localparam int RW = $clog2(T_REFI + 1);
    localparam logic [RW-1:0] LAST = RW'(T_REFI - 1);

    logic [RW-1:0] cnt;
    logic          wrap;

    assign wrap = enable && (cnt == LAST);

    // free-running interval counter
    always_ff @(posedge clk) begin
        if (!rst_n || !enable)
            cnt <= '0;
        else if (wrap)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // owed-refresh flag: a new interval wins over an acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= 1'b0;
        else if (wrap)
            pending <= 1'b1;
        else if (ack)
            pending <= 1'b0;
    end

endmodule

// File: rtl/sdram_cmd_seq.sv
// SDRAM command sequencer: start-up sequence, periodic refresh and
// one-word open/access/close per host request with enforced gaps.
// Assumes ROW_W >= 11 (bit 10 is the auto-precharge bit), COL_W <= 10,
// all gap parameters >= 1, and one access in flight at a time.
module sdram_cmd_seq
    import sdram_seq_pkg::*;
#(
    parameter int BANK_W   = 2,
    parameter int ROW_W    = 11,
    parameter int COL_W    = 8,
    parameter int T_INIT   = 12500,
    parameter int T_RCD    = 3,
    parameter int T_RP     = 3,
    parameter int T_RC     = 10,
    parameter int T_RAS    = 6,
    parameter int T_MRD    = 2,
    parameter int T_WR     = 2,
    parameter int T_RD2PRE = 1,
    parameter int T_REFI   = 1950
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    output logic              req_done,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ROW_W-1:0]  sd_addr
);

    localparam int MAXG  = (T_INIT > T_REFI) ? T_INIT : T_REFI;
    localparam int CNT_W = $clog2(MAXG + 1);
    localparam int N_TM  = 3;
    localparam int TM_GAP = 0;
    localparam int TM_RAS = 1;
    localparam int TM_RC  = 2;
    localparam logic [CNT_W-1:0] G_INIT = CNT_W'(T_INIT - 1);
    localparam logic [CNT_W-1:0] G_RCD  = CNT_W'(T_RCD - 1);
    localparam logic [CNT_W-1:0] G_RP   = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] G_RC   = CNT_W'(T_RC - 1);
    localparam logic [CNT_W-1:0] G_RAS  = CNT_W'(T_RAS - 1);
    localparam logic [CNT_W-1:0] G_MRD  = CNT_W'(T_MRD - 1);
    localparam logic [CNT_W-1:0] G_WR   = CNT_W'(T_WR - 1);
    localparam logic [CNT_W-1:0] G_RD   = CNT_W'(T_RD2PRE - 1);
    localparam logic [ROW_W-1:0] MODE_W = ROW_W'(MODE_WORD);

    seq_state_e        st, st_n;
    sd_cmd_e           cmd_q, cmd_n;
    logic [BANK_W-1:0] ba_n;
    logic [ROW_W-1:0]  addr_n;
    logic              done_n, accept, ref_ack, ref_pend, init_done;
    logic              lat_wr;
    logic [BANK_W-1:0] lat_bank;
    logic [COL_W-1:0]  lat_col;
    logic [N_TM-1:0]   tm_load, tm_exp;
    logic [CNT_W-1:0]  tm_val [N_TM];

    // one gap timer per spacing rule: state gap, row-active, row-cycle
    for (genvar i = 0; i < N_TM; i++) begin : g_tm
        sdram_gap_timer #(.CNT_W(CNT_W)) u_tm (
            .clk(clk), .rst_n(rst_n), .load(tm_load[i]),
            .value(tm_val[i]), .expired(tm_exp[i])
        );
    end

    sdram_refresh_timer #(.T_REFI(T_REFI)) u_refi (
        .clk(clk), .rst_n(rst_n), .enable(init_done),
        .ack(ref_ack), .pending(ref_pend)
    );

    assign req_ready = (st == ST_IDLE) && tm_exp[TM_RC] && !ref_pend;

    // next state and next command selection
    always_comb begin
        st_n    = st;
        cmd_n   = CMD_NOP;
        ba_n    = '0;
        addr_n  = '0;
        done_n  = 1'b0;
        accept  = 1'b0;
        ref_ack = 1'b0;
        tm_load = '0;
        for (int i = 0; i < N_TM; i++) tm_val[i] = '0;
        case (st)
            ST_RST: begin
                cmd_n = CMD_INHIBIT;
                tm_load[TM_GAP] = 1'b1; tm_val[TM_GAP] = G_INIT;
                st_n = ST_PWR;
            end
            ST_PWR: begin
                cmd_n = CMD_INHIBIT;
                if (tm_exp[TM_GAP]) begin
                    cmd_n = CMD_PRE;
                    addr_n[AP_BIT] = 1'b1;
                    tm_load[TM_GAP] = 1'b1; tm_val[TM_GAP] = G_RP;
                    st_n = ST_IREF1;
                end
            end
            ST_IREF1, ST_IREF2: begin
                if (tm_exp[TM_GAP] && tm_exp[TM_RC]) begin
                    cmd_n = CMD_REF;
                    tm_load[TM_RC] = 1'b1; tm_val[TM_RC] = G_RC;
                    st_n = (st == ST_IREF1) ? ST_IREF2 : ST_IMRS;
                end
            end
            ST_IMRS: begin
                if (tm_exp[TM_RC]) begin
                    cmd_n = CMD_LMR;
                    addr_n = MODE_W;
                    tm_load[TM_GAP] = 1'b1; tm_val[TM_GAP] = G_MRD;
                    st_n = ST_IMRW;
                end
            end
            ST_IMRW: if (tm_exp[TM_GAP]) st_n = ST_IDLE;
            ST_IDLE: begin
                if (tm_exp[TM_RC] && ref_pend) begin
                    cmd_n = CMD_REF;
                    ref_ack = 1'b1;
                    tm_load[TM_RC] = 1'b1; tm_val[TM_RC] = G_RC;
                end else if (tm_exp[TM_RC] && req_valid) begin
                    cmd_n = CMD_ACT;
                    ba_n = req_bank;
                    addr_n = req_row;
                    accept = 1'b1;
                    tm_load = '1;
                    tm_val[TM_GAP] = G_RCD;
                    tm_val[TM_RAS] = G_RAS;
                    tm_val[TM_RC]  = G_RC;
                    st_n = ST_RCD;
                end
            end
            ST_RCD: begin
                if (tm_exp[TM_GAP]) begin
                    cmd_n = lat_wr ? CMD_WR : CMD_RD;
                    ba_n = lat_bank;
                    addr_n = ROW_W'(lat_col);
                    tm_load[TM_GAP] = 1'b1;
                    tm_val[TM_GAP] = lat_wr ? G_WR : G_RD;
                    st_n = ST_COL;
                end
            end
            ST_COL: begin
                if (tm_exp[TM_GAP] && tm_exp[TM_RAS]) begin
                    cmd_n = CMD_PRE;
                    ba_n = lat_bank;
                    tm_load[TM_GAP] = 1'b1; tm_val[TM_GAP] = G_RP;
                    st_n = ST_RP;
                end
            end
            ST_RP: begin
                if (tm_exp[TM_GAP]) begin
                    done_n = 1'b1;
                    st_n = ST_IDLE;
                end
            end
            default: st_n = ST_RST;
        endcase
    end

    // state and registered command outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_RST;
            cmd_q     <= CMD_INHIBIT;
            sd_ba     <= '0;
            sd_addr   <= '0;
            req_done  <= 1'b0;
            sd_cke    <= 1'b0;
            init_done <= 1'b0;
        end else begin
            st        <= st_n;
            cmd_q     <= cmd_n;
            sd_ba     <= ba_n;
            sd_addr   <= addr_n;
            req_done  <= done_n;
            sd_cke    <= 1'b1;
            if (st == ST_IMRW && st_n == ST_IDLE) init_done <= 1'b1;
        end
    end

    // request capture on the accepting edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_wr   <= 1'b0;
            lat_bank <= '0;
            lat_col  <= '0;
        end else if (accept) begin
            lat_wr   <= req_write;
            lat_bank <= req_bank;
            lat_col  <= req_col;
        end
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

endmodule

// File: rtl/sdram_cmd_seq_chk.sv
// Port-level checker for sdram_cmd_seq: tracks cycles since each command
// kind with saturating counters and checks the spacing rules.
module sdram_cmd_seq_chk
    import sdram_seq_pkg::*;
#(
    parameter int T_RCD    = 3,
    parameter int T_RP     = 3,
    parameter int T_RC     = 10,
    parameter int T_RAS    = 6,
    parameter int T_MRD    = 2,
    parameter int T_WR     = 2,
    parameter int T_RD2PRE = 1
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic req_done,
    input logic sd_cke,
    input logic sd_cs_n,
    input logic sd_ras_n,
    input logic sd_cas_n,
    input logic sd_we_n
);

    localparam int SW = 8;
    localparam logic [SW-1:0] SMAX = '1;

    logic [3:0]    cmd;
    logic [SW-1:0] s_act, s_pre, s_rc, s_wr, s_rd, s_lmr;
    logic          row_open;

    assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    function automatic logic [SW-1:0] bump(input logic [SW-1:0] x);
        return (x == SMAX) ? x : x + 1'b1;
    endfunction

    // cycles since each command kind, and open-row tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_act <= SMAX; s_pre <= SMAX; s_rc <= SMAX;
            s_wr <= SMAX; s_rd <= SMAX; s_lmr <= SMAX;
            row_open <= 1'b0;
        end else begin
            s_act <= (cmd == CMD_ACT) ? SW'(1) : bump(s_act);
            s_pre <= (cmd == CMD_PRE) ? SW'(1) : bump(s_pre);
            s_rc  <= (cmd == CMD_ACT || cmd == CMD_REF) ? SW'(1) : bump(s_rc);
            s_wr  <= (cmd == CMD_WR) ? SW'(1) : bump(s_wr);
            s_rd  <= (cmd == CMD_RD) ? SW'(1) : bump(s_rd);
            s_lmr <= (cmd == CMD_LMR) ? SW'(1) : bump(s_lmr);
            if (cmd == CMD_ACT) row_open <= 1'b1;
            else if (cmd == CMD_PRE) row_open <= 1'b0;
        end
    end

    // R2
    cke_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sd_cke |=> sd_cke);
    // R5
    hs_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (cmd == CMD_ACT));
    // R5
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_open |-> !req_ready);
    // R6
    rcd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_RD || cmd == CMD_WR) |-> (s_act >= SW'(T_RCD)));
    // R7
    ras_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRE) |-> (s_act >= SW'(T_RAS)));
    // R7
    wr_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRE) |-> (s_wr >= SW'(T_WR) && s_rd >= SW'(T_RD2PRE)));
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |=> !req_done);
    // R9
    rc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACT || cmd == CMD_REF) |-> (s_rc >= SW'(T_RC)));
    // R9
    rp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACT || cmd == CMD_REF) |-> (s_pre >= SW'(T_RP)));
    // R9
    mrd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACT || cmd == CMD_REF) |-> (s_lmr >= SW'(T_MRD)));
    // R10
    ref_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_REF) |-> !row_open);

endmodule

bind sdram_cmd_seq sdram_cmd_seq_chk #(
    .T_RCD(T_RCD), .T_RP(T_RP), .T_RC(T_RC), .T_RAS(T_RAS),
    .T_MRD(T_MRD), .T_WR(T_WR), .T_RD2PRE(T_RD2PRE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_done(req_done), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n)
);

// File: tb/sim_sdram_cmd_seq.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues the expected command stream,
// the monitor pops and compares it with exact due cycles.
module sim_sdram_cmd_seq;

    localparam int CLK_PERIOD = 8;
    localparam int T_INIT = 300, T_REFI = 250;
    localparam int T_RCD = 3, T_RP = 3, T_RC = 10, T_RAS = 6;
    localparam int T_MRD = 2, T_WR = 2, T_RD2PRE = 1;
    localparam logic [3:0] C_INH = 4'b1111, C_NOP = 4'b0111, C_ACT = 4'b0011,
        C_RD = 4'b0101, C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
        C_LMR = 4'b0000;

    typedef struct {
        logic [3:0]  cmd;
        logic        chk_ab;
        logic [1:0]  ba;
        logic [10:0] addr;
    } exp_t;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_write = 0;
    logic [1:0] req_bank = 0;
    logic [10:0] req_row = 0;
    logic [7:0] req_col = 0;
    logic req_ready, req_done, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0] sd_ba;
    logic [10:0] sd_addr;

    int n_chk = 0, n_fail = 0, cyc = 0;
    exp_t exp_q[$];
    int acc_cyc = -1, act_cyc = -1000, col_cyc = -1000, pre_cyc = -1000;
    int rc_cyc = -1000, lmr_cyc = -1000, pref_cyc = -1;
    int n_req = 0, n_done = 0, n_pref = 0;
    logic col_wr = 0, row_open = 0, first_seen = 0, lmr_seen = 0;

    sdram_cmd_seq #(.T_INIT(T_INIT), .T_REFI(T_REFI)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_bank(req_bank), .req_row(req_row),
        .req_col(req_col), .req_done(req_done), .sd_cke(sd_cke),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

    task automatic chk(input logic ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, expv);
        end
    endtask

    task automatic push(input logic [3:0] c, input logic ab, input logic [1:0] b, input logic [10:0] a);
        exp_t e;
        e.cmd = c; e.chk_ab = ab; e.ba = b; e.addr = a;
        exp_q.push_back(e);
    endtask

    task automatic do_req(input logic wr, input logic [1:0] b, input logic [10:0] r, input logic [7:0] c);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = wr; req_bank = b; req_row = r; req_col = c;
        acc_cyc = cyc + 1;
        push(C_ACT, 1, b, r);
        push(wr ? C_WR : C_RD, 1, b, {3'b000, c});
        push(C_PRE, 1, b, 11'd0);
        n_req++;
        @(negedge clk);
        req_valid = 0;
    endtask

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // monitor: compares every non-idle command and the done pulse
    always @(negedge clk) begin
        logic [3:0] c;
        c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        if (rst_n) begin
            if (c != C_INH && c != C_NOP) begin
                if (!first_seen) begin
                    first_seen = 1;
                    // R2: quiet wait before the first command
                    chk(cyc >= T_INIT, "R2 start-up wait", cyc, T_INIT);
                    chk(sd_cke == 1'b1, "R2 cke high", sd_cke, 1);
                end
                if (c == C_REF && (exp_q.size() == 0 || exp_q[0].cmd != C_REF)) begin
                    // R10: periodic refresh only with no row open, on schedule
                    chk(!row_open, "R10 refresh with row open", row_open, 0);
                    if (pref_cyc >= 0)
                        chk((cyc - pref_cyc) >= T_REFI - 25 && (cyc - pref_cyc) <= T_REFI + 25,
                            "R10 refresh interval", cyc - pref_cyc, T_REFI);
                    pref_cyc = cyc;
                    n_pref++;
                end else if (exp_q.size() == 0) begin
                    chk(0, "R4 unexpected command", c, C_NOP);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    // R3 R4: command order and encoding
                    chk(c == e.cmd, "R4 command code", c, e.cmd);
                    if (e.chk_ab) begin
                        chk(sd_ba == e.ba, "R4 bank", sd_ba, e.ba);
                        chk(sd_addr == e.addr, "R3 address", sd_addr, e.addr);
                    end
                end
                case (c)
                    C_ACT: begin
                        chk(cyc == acc_cyc, "R5 ACTIVE latency", cyc, acc_cyc);
                        chk(cyc - rc_cyc >= T_RC, "R9 row cycle gap", cyc - rc_cyc, T_RC);
                        chk(cyc - pre_cyc >= T_RP, "R9 precharge gap", cyc - pre_cyc, T_RP);
                        chk(cyc - lmr_cyc >= T_MRD, "R9 mode gap", cyc - lmr_cyc, T_MRD);
                        act_cyc = cyc; rc_cyc = cyc; row_open = 1;
                    end
                    C_RD, C_WR: begin
                        chk(cyc == act_cyc + T_RCD, "R6 column latency", cyc, act_cyc + T_RCD);
                        col_cyc = cyc; col_wr = (c == C_WR);
                    end
                    C_PRE: begin
                        if (sd_addr[10] == 1'b0) begin
                            int due;
                            due = max2(act_cyc + T_RAS, col_cyc + (col_wr ? T_WR : T_RD2PRE));
                            chk(cyc == due, "R7 precharge timing", cyc, due);
                        end
                        pre_cyc = cyc; row_open = 0;
                    end
                    C_REF: begin
                        chk(cyc - rc_cyc >= T_RC, "R9 refresh cycle gap", cyc - rc_cyc, T_RC);
                        chk(cyc - pre_cyc >= T_RP, "R9 refresh after precharge", cyc - pre_cyc, T_RP);
                        rc_cyc = cyc;
                    end
                    C_LMR: begin lmr_cyc = cyc; lmr_seen = 1; end
                    default: ;
                endcase
            end
            if (req_ready)
                chk(lmr_seen && !row_open, "R3 R5 ready only when idle after start-up", req_ready, 0);
            if (req_done) begin
                chk(cyc == pre_cyc + T_RP, "R8 done latency", cyc, pre_cyc + T_RP);
                n_done++;
            end
        end
    end

    // watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin
        // start-up stream, R3
        push(C_PRE, 1, 2'd0, 11'h400);
        push(C_REF, 0, 2'd0, 11'd0);
        push(C_REF, 0, 2'd0, 11'd0);
        push(C_LMR, 1, 2'd0, 11'h030);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_INH, "R1 inhibit in reset",
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_INH);
        chk(sd_cke == 1'b0, "R1 cke low in reset", sd_cke, 0);
        chk(req_ready == 1'b0 && req_done == 1'b0, "R1 ready/done low", req_ready, 0);
        @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk(sd_cke == 1'b1, "R2 cke after reset", sd_cke, 1);
        // single read, single write, boundary addresses
        do_req(0, 2'd1, 11'd5, 8'd9);
        do_req(1, 2'd2, 11'd2047, 8'd255);
        do_req(1, 2'd3, 11'd0, 8'd0);
        do_req(0, 2'd0, 11'd1024, 8'd128);
        // mixed traffic spanning several refresh intervals
        for (int i = 0; i < 60; i++) begin
            do_req(i[0], i[1:0], 11'((i * 37) % 2048), 8'((i * 53) % 256));
            for (int k = 0; k < (i % 3); k++) @(negedge clk);
        end
        repeat (2 * T_REFI) @(negedge clk);
        chk(exp_q.size() == 0, "R4 all expected commands seen", exp_q.size(), 0);
        chk(n_done == n_req, "R8 one done per request", n_done, n_req);
        chk(n_pref >= 3, "R10 periodic refreshes issued", n_pref, 3);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule